// File: doc/BRIEF.md
# Gated-Edge Non-Retriggerable Pulse Generator

This block is a clocked one-shot. It watches three asynchronous control lines and fires one pulse of programmable length when a qualified edge occurs. There are three such edges. The first is a falling edge on the fall-trigger line. The second is a rising edge on the rise-trigger line. The third is the release of an active-low clear. Each trigger line also acts as a gate for the other two edges. While the fall-trigger line is high, or the rise-trigger line is low, no pulse can begin. The pulse length is counted in clock cycles from a width input, so no timing components are needed.

All three lines pass through a two-stage synchroniser. Edges are then found by comparing each synchronised level with its level one cycle earlier. Once a pulse has started, further activity on the trigger lines is ignored until the pulse ends. Pulling the clear line low stops a running pulse and keeps the output low for as long as clear stays low. The block drives a true output and a complementary output.

Top module: `oneshot_dual_trig`

## Requirements
- R1: A falling edge on `trig_fall_i` starts a pulse when `trig_rise_i` and `clr_n_i` are both high after that edge.
- R2: A rising edge on `trig_rise_i` starts a pulse when `trig_fall_i` is low and `clr_n_i` is high after that edge.
- R3: A rising edge on `clr_n_i` starts a pulse when `trig_fall_i` is low and `trig_rise_i` is high after that edge.
- R4: No other change of the three input levels starts a pulse. This includes any edge that occurs while `trig_fall_i` is high, while `trig_rise_i` is low, or while `clr_n_i` is low.
- R5: When `clr_n_i` is low, `pulse_o` goes to 0 by the third rising clock edge and stays 0 while clear stays low. This ends any pulse that is running.
- R6: While a pulse runs, input transitions neither lengthen nor restart it. An edge seen during a pulse is not remembered after the pulse ends.
- R7: A pulse lasts exactly `width_cfg` clock cycles, with a value of 0 giving 1 cycle. `width_cfg` is sampled only in the cycle the pulse starts.
- R8: `pulse_n_o` is always the complement of `pulse_o`.
- R9: An input change made between clock edges shows as a high `pulse_o` after the third rising clock edge that follows it.
- R10: When several qualifying edges arrive in the same cycle, exactly one pulse results.
- R11: During reset `pulse_o` is 0. Input levels that are already present when reset is released do not start a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_fall_i | input | 1 | Trigger line that fires on its falling edge; when high it blocks all triggering |
| trig_rise_i | input | 1 | Trigger line that fires on its rising edge; when low it blocks all triggering |
| clr_n_i | input | 1 | Active-low clear; its release is also a trigger |
| width_cfg | input | CNT_W | Pulse length in clock cycles (0 behaves as 1) |
| pulse_o | output | 1 | Pulse output, high while the pulse runs |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
The bench steps through every ordered pair of the eight levels of the three control lines. For each pair it predicts from the R1 to R4 formulas whether a pulse must appear. This shows that only the three gated edges fire, and that several edges changing together (R10) still give a single pulse. A sweep of `width_cfg`, including 0 and the maximum, confirms the exact length and the fixed latency. Directed sequences toggle the trigger lines and `width_cfg` in the middle of a pulse. This separates a truly non-retriggerable design from one that reloads or queues a trigger. Further sequences pull clear low in mid-pulse and release it with the block gated, which separates a clear that ends the pulse from one that only blocks new pulses.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef enum logic {
        OS_IDLE   = 1'b0,
        OS_ACTIVE = 1'b1
    } os_state_e;

    typedef struct packed {
        logic fall;
        logic rise;
        logic clr;
    } os_pins_t;

    localparam int OS_PINS = 3;

endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [N-1:0] stage_d [STAGES];
    logic [N-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d[g];
        end
    end

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/os_edge.sv
module os_edge
    import oneshot_pkg::*;
#(
    parameter int WARM_CYCLES = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  os_pins_t lvl_i,
    output logic     fire_o,
    output logic     clr_o
);
    localparam int WARM_W = $clog2(WARM_CYCLES + 1);
    localparam logic [WARM_W-1:0] WARM_DONE = WARM_W'(WARM_CYCLES);

    typedef struct packed {
        os_pins_t          prev;
        logic [WARM_W-1:0] warm;
    } edge_regs_t;

    edge_regs_t r_d, r_q;
    logic fall_a, rise_b, rise_c, ready;

    always_comb begin
        r_d      = r_q;
        r_d.prev = lvl_i;
        if (r_q.warm != WARM_DONE) r_d.warm = r_q.warm + 1'b1;

        ready  = (r_q.warm == WARM_DONE);
        fall_a = r_q.prev.fall & ~lvl_i.fall;
        rise_b = ~r_q.prev.rise & lvl_i.rise;
        rise_c = ~r_q.prev.clr & lvl_i.clr;

        fire_o = ready & ((fall_a &  lvl_i.rise &  lvl_i.clr) |
                          (rise_b & ~lvl_i.fall &  lvl_i.clr) |
                          (rise_c & ~lvl_i.fall &  lvl_i.rise));
        clr_o  = lvl_i.clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/os_timer.sv
module os_timer
    import oneshot_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             active_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        os_state_e        st;
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!clr_i) begin
            r_d.st  = OS_IDLE;
            r_d.cnt = '0;
        end else begin
            case (r_q.st)
                OS_IDLE: begin
                    if (fire_i) begin
                        r_d.st  = OS_ACTIVE;
                        r_d.cnt = (width_i == '0) ? CNT_ONE : width_i;
                    end
                end
                OS_ACTIVE: begin
                    if (r_q.cnt <= CNT_ONE) begin
                        r_d.st  = OS_IDLE;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt - CNT_ONE;
                    end
                end
                default: r_d.st = OS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= OS_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign active_o = (r_q.st == OS_ACTIVE);

    // R5: a low clear always returns the FSM to idle
    a_r5_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (r_q.st == OS_IDLE));

    // R1: a qualified trigger seen while idle starts a pulse
    a_r1_fire_start: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == OS_IDLE && fire_i && clr_i) |=> (r_q.st == OS_ACTIVE));

    // R4: the edge detector never reports a trigger while clear is low
    a_r4_clr_gate: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |-> clr_i);

    // R7: the counter is loaded from the width sampled at the start
    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == OS_ACTIVE && $past(r_q.st) == OS_IDLE) |->
        (r_q.cnt == (($past(width_i) == '0) ? CNT_ONE : $past(width_i))));

    // R6: a running pulse counts down regardless of triggers
    a_r6_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == OS_ACTIVE && r_q.cnt > CNT_ONE && clr_i) |=>
        (r_q.st == OS_ACTIVE && r_q.cnt == CNT_W'($past(r_q.cnt) - CNT_ONE)));

endmodule

// File: rtl/oneshot_dual_trig.sv
module oneshot_dual_trig
    import oneshot_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_fall_i,
    input  logic             trig_rise_i,
    input  logic             clr_n_i,
    input  logic [CNT_W-1:0] width_cfg,
    output logic             pulse_o,
    output logic             pulse_n_o
);
    localparam int SYNC_STAGES = 2;
    localparam int WARM        = SYNC_STAGES + 1;

    logic [OS_PINS-1:0] raw_pins, sync_pins;
    os_pins_t           lvl;
    logic               fire, clr_lvl, active;

    assign raw_pins = {trig_fall_i, trig_rise_i, clr_n_i};

    os_sync #(
        .N      (OS_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_pins),
        .sync_o  (sync_pins)
    );

    assign lvl = os_pins_t'(sync_pins);

    os_edge #(
        .WARM_CYCLES (WARM)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .fire_o (fire),
        .clr_o  (clr_lvl)
    );

    os_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire),
        .clr_i    (clr_lvl),
        .width_i  (width_cfg),
        .active_o (active)
    );

    assign pulse_o   = active;
    assign pulse_n_o = ~active;

endmodule

// File: tb/sim_oneshot_dual_trig.sv
module sim_oneshot_dual_trig;
    localparam int CW = 8;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          a     = 1'b0;
    logic          b     = 1'b1;
    logic          clr_n = 1'b1;
    logic [CW-1:0] wcfg  = CW'(4);
    logic          q, qn;
    int            vectors = 0;
    int            errors  = 0;
    bit            done    = 1'b0;

    always #10 clk = ~clk;

    oneshot_dual_trig #(.CNT_W(CW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_fall_i (a),
        .trig_rise_i (b),
        .clr_n_i     (clr_n),
        .width_cfg   (wcfg),
        .pulse_o     (q),
        .pulse_n_o   (qn)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pins(input logic [2:0] p);
        a = p[2]; b = p[1]; clr_n = p[0];
    endtask

    // Called right after inputs change at a falling clock edge.
    task automatic measure(input int exp_w, input int win, input string req);
        int first = -1;
        int cnt   = 0;
        bit compl = 1'b1;
        for (int i = 1; i <= win; i++) begin
            @(negedge clk);
            if (qn !== ~q) compl = 1'b0;
            if (q === 1'b1) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
        chk(cnt == exp_w, req, cnt, exp_w);
        if (exp_w > 0) chk(first == 3, {req, " latency R9"}, first, 3);
        chk(compl, "R8 complement", int'(compl), 1);
    endtask

    // Expected trigger from the R1..R3 rules; bit 2 = fall line, bit 1 = rise line, bit 0 = clear.
    function automatic bit exp_fire(input logic [2:0] p, input logic [2:0] n);
        bit fa, rb, rc;
        fa = p[2] & ~n[2];
        rb = ~p[1] & n[1];
        rc = ~p[0] & n[0];
        return (fa & n[1] & n[0]) | (rb & ~n[2] & n[0]) | (rc & ~n[2] & n[1]);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        // R11: reset state and no pulse from levels present at release
        idle(3);
        chk(q === 1'b0 && qn === 1'b1, "R11 reset outputs", int'(q), 0);
        rst_n = 1'b1;
        measure(0, 10, "R11 no pulse on release");

        // R1, R2, R3, R4, R10: every ordered pair of input levels
        wcfg = CW'(2);
        for (int p = 0; p < 8; p++) begin
            for (int n = 0; n < 8; n++) begin
                set_pins(3'(p));
                idle(12);
                set_pins(3'(n));
                measure(exp_fire(3'(p), 3'(n)) ? 2 : 0, 10,
                        $sformatf("R1 R2 R3 R4 R10 sweep %0d->%0d", p, n));
            end
        end

        // R7: width sweep through the fall trigger, including 0 and maximum
        set_pins(3'b111);
        idle(6);
        for (int w = 0; w <= 16; w++) begin
            int wv;
            wv = (w == 16) ? 255 : w;
            wcfg = CW'(wv);
            a = 1'b0;
            measure((wv == 0) ? 1 : wv, wv + 8, $sformatf("R7 width %0d", wv));
            a = 1'b1;
            idle(4);
        end

        // R7: width changed mid-pulse is not used
        set_pins(3'b001);
        wcfg = CW'(6);
        idle(6);
        b = 1'b1;
        cnt = 0;
        for (int i = 1; i <= 14; i++) begin
            @(negedge clk);
            if (q === 1'b1) cnt++;
            if (i == 4) wcfg = CW'(1);
        end
        chk(cnt == 6, "R7 width sampled at start", cnt, 6);

        // R6: transitions during a pulse are ignored and not remembered
        set_pins(3'b001);
        wcfg = CW'(8);
        idle(6);
        b = 1'b1;
        cnt = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (q === 1'b1) cnt++;
            case (i)
                4: b = 1'b0;
                5: b = 1'b1;
                6: a = 1'b1;
                7: a = 1'b0;
                default: ;
            endcase
        end
        chk(cnt == 8, "R6 no retrigger", cnt, 8);

        // R5: clear ends a running pulse and holds the output low
        set_pins(3'b001);
        wcfg = CW'(20);
        idle(6);
        b = 1'b1;
        cnt = 0;
        for (int i = 1; i <= 24; i++) begin
            @(negedge clk);
            if (q === 1'b1) cnt++;
            if (i == 5) begin
                clr_n = 1'b0;
                a     = 1'b1;
            end
        end
        chk(cnt == 5, "R5 clear terminates pulse", cnt, 5);
        a = 1'b0; b = 1'b0;
        idle(4);
        b = 1'b1;
        measure(0, 10, "R5 clear low blocks rise trigger");
        a = 1'b1;
        idle(4);
        clr_n = 1'b1;
        measure(0, 10, "R4 clear release with fall line high");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule